// File: doc/BRIEF.md
# I2C target address matcher

This block is the address recognition front end of an I2C target. After every START or repeated START it collects the first byte on the bus, MSB first, on SCL rising edges. It then compares that byte with a programmed target address under a programmed mask. On a hit it pulls SDA low through the acknowledge clock, pulses a match strobe and reports the read/write direction to the rest of the target logic. On a miss it stays off the bus until the next START.

Address and mask share one layout: bits 7:1 carry the value and bit 0 is reserved. A mask bit of 1 makes the matching address bit significant, and a mask bit of 0 makes it a don't-care. In 10-bit mode only the header byte is examined: its fixed prefix and the two top address bits. The second address byte and the data phase belong to other logic.

Top module: `i2c_addr_match`

## Requirements
- R1: While rst_ni is low and after its release, sda_low_o, match_o and dir_o are all 0.
- R2: After a START, eight bits are sampled MSB first on SCL rising edges. Received bit 0 is the direction (1 = read), and it appears on dir_o together with the match pulse. dir_o keeps its value until the next match.
- R3: In 7-bit mode (ten_bit_i = 0) a byte matches when, for every bit position i from 7 down to 1 where mask_i[i] = 1, received bit i equals addr_i[i]. addr_i[0] and mask_i[0] have no effect on the result.
- R4: With mask_i[7:1] all 0, every received 7-bit address matches, whatever the direction bit.
- R5: On a match, match_o is high for exactly one clock cycle. That cycle directly follows the clock edge on which the eighth SCL rising edge is seen.
- R6: On a match, sda_low_o rises in the cycle after the SCL falling edge that ends bit 8. It stays high through the whole ninth SCL high period and returns to 0 in the cycle after the SCL falling edge that ends bit 9.
- R7: On a mismatch, sda_low_o stays 0 and match_o does not pulse. Following bytes are ignored (no acknowledge, no pulse) until the next START.
- R8: A START (start_i high) in the middle of a byte restarts bit collection, so the next eight SCL rising edges form a fresh address byte. A START also releases sda_low_o in the following cycle.
- R9: In 10-bit mode (ten_bit_i = 1) a byte matches only when received bits 7:3 equal 11110 and, for i in 2..1 with mask_i[i] = 1, received bit i equals addr_i[i]. addr_i[7:3] is ignored in this mode.
- R10: After the acknowledge of a matched address, later bytes are neither acknowledged nor reported until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| start_i | input | 1 | One-cycle START / repeated START detect |
| addr_i | input | 8 | Target address, value in bits 7:1 |
| mask_i | input | 8 | Address compare mask, value in bits 7:1 |
| ten_bit_i | input | 1 | 1 selects 10-bit header matching |
| sda_low_o | output | 1 | 1 pulls SDA low (acknowledge) |
| match_o | output | 1 | One-cycle address match strobe |
| dir_o | output | 1 | Direction of the last matched byte, 1 = read |

## Verification
The assertions check on every cycle the timing relations of the outputs to SCL. The match strobe is a single cycle that follows an SCL rise. The acknowledge drive starts only on an SCL fall and never changes while SCL stays high. A START releases the drive. The direction bit moves only with the strobe. Whether a given byte should match at all is something only the bench scenarios can show, along with mask and reserved-bit handling, the 10-bit header rule, restarting mid-byte and the ignoring of bytes after a miss or after a matched acknowledge. The bench checks these at the ports through the acknowledge level and the queued match outcomes.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned HDR_W   = 5;
  localparam logic [HDR_W-1:0] HDR_10B = 5'b11110;

  typedef enum logic [1:0] {
    S_SKIP,  // off the bus until START
    S_ADDR,  // collecting address byte
    S_ACKW,  // matched, waiting for end of bit 8
    S_ACK    // driving ACK through bit 9
  } am_state_e;
endpackage

// File: rtl/i2c_am_edge.sv
module i2c_am_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_q <= 1'b1;
    else         scl_q <= scl_i;
  end

  assign rise_o = scl_i & ~scl_q;
  assign fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         shift_i,
  input  logic         sda_i,
  output logic [W-1:0] byte_o,
  output logic         last_o
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-2:0]     sh_q;
  logic             take;

  assign byte_o = {sh_q, sda_i};
  assign take   = en_i & shift_i & ~clr_i;
  assign last_o = take & (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (take) begin
      sh_q  <= byte_o[W-2:0];
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
  parameter int unsigned W   = 8,
  parameter int unsigned HW  = 5,
  parameter logic [HW-1:0] HDR = 5'b11110
) (
  input  logic [W-1:0] byte_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] mask_i,
  input  logic         ten_bit_i,
  output logic         hit_o
);
  localparam int unsigned TAIL_HI = W - HW - 1;

  logic [W-1:1] bit_ok;
  logic         hit7, hdr_ok, tail_ok;
  logic         unused_rsvd;

  for (genvar i = 1; i < W; i++) begin : g_bit
    assign bit_ok[i] = ~mask_i[i] | (byte_i[i] == addr_i[i]);
  end

  assign hit7    = &bit_ok;
  assign hdr_ok  = (byte_i[W-1 -: HW] == HDR);
  assign tail_ok = &bit_ok[TAIL_HI:1];
  assign hit_o   = ten_bit_i ? (hdr_ok & tail_ok) : hit7;

  // reserved bit 0 never takes part in the compare
  assign unused_rsvd = ^{byte_i[0], addr_i[0], mask_i[0]};
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] mask_i,
  input  logic              ten_bit_i,
  output logic              sda_low_o,
  output logic              match_o,
  output logic              dir_o
);
  am_state_e         state_q;
  logic              rise, fall, last, hit;
  logic [BYTE_W-1:0] rx_byte;
  logic              match_q, dir_q, ack_q;

  i2c_am_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  i2c_am_shift #(.W(BYTE_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .en_i    (state_q == S_ADDR),
    .shift_i (rise),
    .sda_i   (sda_i),
    .byte_o  (rx_byte),
    .last_o  (last)
  );

  i2c_am_cmp #(.W(BYTE_W), .HW(HDR_W), .HDR(HDR_10B)) u_cmp (
    .byte_i    (rx_byte),
    .addr_i    (addr_i),
    .mask_i    (mask_i),
    .ten_bit_i (ten_bit_i),
    .hit_o     (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_SKIP;
      match_q <= 1'b0;
      dir_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      match_q <= 1'b0;
      if (start_i) begin
        state_q <= S_ADDR;
        ack_q   <= 1'b0;
      end else begin
        unique case (state_q)
          S_ADDR: if (last) begin
            if (hit) begin
              state_q <= S_ACKW;
              match_q <= 1'b1;
              dir_q   <= rx_byte[0];
            end else begin
              state_q <= S_SKIP;
            end
          end
          S_ACKW: if (fall) begin
            state_q <= S_ACK;
            ack_q   <= 1'b1;
          end
          S_ACK: if (fall) begin
            state_q <= S_SKIP;
            ack_q   <= 1'b0;
          end
          default: state_q <= S_SKIP;
        endcase
      end
    end
  end

  assign sda_low_o = ack_q;
  assign match_o   = match_q;
  assign dir_o     = dir_q;
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic start_i,
  input logic sda_low_o,
  input logic match_o,
  input logic dir_o
);
  p_match_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  p_match_after_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ($past(scl_i) && !$past(scl_i, 2)));

  p_dir_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> $stable(dir_o));

  p_ack_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> (!$past(scl_i) && $past(scl_i, 2)));

  p_ack_steady_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && !$past(start_i)) |-> $stable(sda_low_o));

  p_start_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i) |-> !sda_low_o);
endmodule

bind i2c_addr_match i2c_am_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .start_i   (start_i),
  .sda_low_o (sda_low_o),
  .match_o   (match_o),
  .dir_o     (dir_o)
);

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
  localparam int CLK_PERIOD = 10;
  localparam int HP         = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_drv = 1'b1;
  logic       start = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] mask = 8'hFE;
  logic       ten = 1'b0;
  logic       sda_low, match, dir;
  logic       sda_line;

  int n_chk  = 0;
  int n_fail = 0;
  bit exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_drv & ~sda_low;  // open-drain bus

  i2c_addr_match dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .start_i   (start),
    .addr_i    (addr),
    .mask_i    (mask),
    .ten_bit_i (ten),
    .sda_low_o (sda_low),
    .match_o   (match),
    .dir_o     (dir)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: each match strobe pops one expected direction
  always @(negedge clk) begin
    if (rst_n && match) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected match", 1, 0);
      end else begin
        check("R2 dir on match", int'(dir), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic bus_start();
    sda_drv = 1'b1; scl = 1'b1; tick(HP);
    sda_drv = 1'b0; start = 1'b1; tick(1);
    start = 1'b0; tick(HP);
    scl = 1'b0; tick(HP);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(HP);
    scl = 1'b1; tick(HP);
    sda_drv = 1'b1; tick(HP);
  endtask

  task automatic send_bit(bit b);
    sda_drv = b; tick(HP);
    scl = 1'b1; tick(HP);
    scl = 1'b0; tick(HP);
  endtask

  task automatic ack_slot(bit exp_ack, string req);
    check({req, " no drive before ack"}, int'(sda_low), int'(exp_ack));
    sda_drv = 1'b1; tick(HP);
    scl = 1'b1; tick(HP/2);
    check({req, " ack level"}, int'(sda_low), int'(exp_ack));
    tick(HP - HP/2);
    scl = 1'b0; tick(HP);
    check("R6 ack released", int'(sda_low), 0);
  endtask

  // driver: pushes expected outcome, clocks a byte, checks ack and strobe
  task automatic send_byte(logic [7:0] b, bit exp_hit, string req);
    if (exp_hit) exp_q.push_back(b[0]);
    for (int i = 7; i >= 0; i--) begin
      send_bit(b[i]);
      if (i > 0) check({req, " quiet during byte"}, int'(sda_low), 0);
    end
    ack_slot(exp_hit, req);
    check({req, " strobe count"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic addr_xfer(logic [7:0] b, bit exp_hit, string req);
    bus_start();
    send_byte(b, exp_hit, req);
    bus_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 reset sda_low", int'(sda_low), 0);
    check("R1 reset match", int'(match), 0);
    check("R1 reset dir", int'(dir), 0);
    rst_n = 1'b1;
    tick(3);
    check("R1 after reset sda_low", int'(sda_low), 0);
    check("R1 after reset dir", int'(dir), 0);

    // R3 exact 7-bit compare
    addr = 8'hB4; mask = 8'hFE; ten = 1'b0;
    addr_xfer(8'hB4, 1'b1, "R3 write hit");
    addr_xfer(8'hB5, 1'b1, "R2 read hit");
    check("R2 dir holds", int'(dir), 1);
    addr_xfer(8'hB6, 1'b0, "R3 miss");
    check("R2 dir holds after miss", int'(dir), 1);

    // R7 miss then bytes ignored until START
    bus_start();
    send_byte(8'h34, 1'b0, "R7 miss");
    send_byte(8'hB4, 1'b0, "R7 ignored byte");
    bus_stop();

    // R10 data phase after matched ack ignored; repeated START rematches
    bus_start();
    send_byte(8'hB4, 1'b1, "R10 hit");
    send_byte(8'hB4, 1'b0, "R10 data ignored");
    bus_start();
    send_byte(8'hB5, 1'b1, "R10 repeated start hit");
    bus_stop();

    // R3 mask don't-care bits
    mask = 8'hF0;
    addr_xfer(8'hBA, 1'b1, "R3 masked hit");
    addr_xfer(8'hA4, 1'b0, "R3 masked miss");

    // R4 all-zero mask
    mask = 8'h00;
    addr_xfer(8'h12, 1'b1, "R4 any addr");
    addr_xfer(8'hFF, 1'b1, "R4 any addr read");

    // R3 reserved bit 0 of addr and mask ignored
    addr = 8'hB5; mask = 8'hFF;
    addr_xfer(8'hB4, 1'b1, "R3 rsvd addr bit");
    mask = 8'h01;
    addr_xfer(8'h6B, 1'b1, "R3 rsvd mask bit");

    // R8 START mid-byte restarts collection
    addr = 8'hB4; mask = 8'hFE;
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start();
    send_byte(8'hB4, 1'b1, "R8 restart hit");
    bus_stop();
    bus_start();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_start();
    send_byte(8'h34, 1'b0, "R8 restart miss");
    bus_stop();

    // R9 10-bit header
    ten = 1'b1; addr = 8'hA4; mask = 8'hFE;
    addr_xfer(8'hF4, 1'b1, "R9 header hit");
    addr_xfer(8'hF5, 1'b1, "R9 header read");
    addr_xfer(8'hF2, 1'b0, "R9 top bits miss");
    addr_xfer(8'hA4, 1'b0, "R9 bad prefix");
    mask = 8'h00;
    addr_xfer(8'hF6, 1'b1, "R9 masked top bits");
    addr_xfer(8'h76, 1'b0, "R9 prefix unmasked");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule